// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a two-channel serial audio stream (bit clock, channel-select clock and data) and turns it into parallel samples. All three serial lines are treated as slow signals. They are resynchronised into the system clock domain, and a data bit is taken only when the synchronised bit clock rises. Each finished half-frame is delivered as a 24-bit two's-complement sample, with a one-cycle valid strobe and a flag that says whether it belongs to the right channel.

Two quasi-static configuration inputs set the framing and the word length. The framing is I2S (MSB delayed by one bit clock), left-justified (MSB on the first bit clock) or right-justified (LSB on the last bit clock). The word length is 16, 18, 20 or 24 bits. Configuration is taken only when a left half-frame begins, so one stereo pair is always decoded with a single setting.

Control is a four-state machine:
- `ST_ARM`: after reset, waiting to see the channel clock high.
- `ST_SYNC`: waiting for the first falling channel clock.
- `ST_LEFT`: receiving a left half-frame.
- `ST_RIGHT`: receiving a right half-frame.

All transitions are evaluated only on a bit-clock rise:
- ARM→SYNC: the channel clock is sampled high.
- SYNC→LEFT: the channel clock is sampled low. This is the first left start; configuration is latched and nothing is emitted.
- LEFT→RIGHT: the channel clock is sampled high. The left sample is emitted.
- RIGHT→LEFT: the channel clock is sampled low. The right sample is emitted and configuration is latched.
- In all other cases the state holds.

I2S framing needs at least N+1 bit clocks per half-frame. The other two framings need at least N.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset, `smp_valid`, `smp_data` and `smp_right` are 0. No sample is emitted until a left half-frame that began after the first observed high-to-low channel-clock change has completed. The partial frame seen after reset is discarded.
- R2: A channel clock sampled low marks a left half-frame, and sampled high marks a right half-frame. `smp_right` equals the channel-clock level of the half-frame whose sample is being emitted.
- R3: Data and channel clock are taken only at rising bit-clock edges. Changes of `sdata_in` while the bit clock is high, or while it is idle, have no effect.
- R4: With `fmt_sel`=01 (left-justified), the bit taken at the first rising edge of a half-frame (index 0) is the MSB, followed by the next N-1 bits, MSB first.
- R5: With `fmt_sel`=00 (I2S) or the spare code 11, the MSB is the bit at index 1, followed by N-1 more bits.
- R6: With `fmt_sel`=10 (right-justified), the sample is the last N bits taken before the channel clock changes, with the LSB last.
- R7: In I2S and left-justified framing, bits outside the N-bit window of a half-frame do not alter the sample.
- R8: `width_sel` codes 00, 01, 10 and 11 select N = 16, 18, 20 and 24. The emitted sample is the N-bit word sign-extended from bit N-1 to 24 bits.
- R9: A half-frame's sample is emitted when the bit-clock rise that opens the next half-frame is seen. It is decoded with the configuration latched at the last left start.
- R10: `smp_valid` is high for exactly one clock, on the third system clock edge after the bit-clock rise that opens the next half-frame. `smp_data` and `smp_right` hold until the next pulse.
- R11: `fmt_sel` and `width_sel` are latched only when a left half-frame starts. A change while a pair is in progress takes effect from the next left start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| lrclk_in | input | 1 | Channel-select clock, low = left |
| sdata_in | input | 1 | Serial data |
| fmt_sel | input | 2 | Framing: 00 I2S, 01 left-just., 10 right-just., 11 as I2S |
| width_sel | input | 2 | Word length: 00=16, 01=18, 10=20, 11=24 |
| smp_data | output | 24 | Sign-extended sample |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_right | output | 1 | 1 when the sample is right channel |

## Verification
With the default two-stage synchroniser, a bit-clock rise driven on a falling system clock edge becomes visible to the state machine after two rising edges. The sample register updates on the third rising edge. The bench therefore samples the outputs on the falling system clock edge that follows that third edge, in the bit period that opens each half-frame. It expects a strobe only in that slot, carrying the previous half-frame's word. A separate monitor counts every strobe at every falling edge, and the final check requires that count to match the pulses seen in the expected slots. This catches a pulse that is early, late or too long.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S   = 2'b00,
        FMT_LJUST = 2'b01,
        FMT_RJUST = 2'b10,
        FMT_SPARE = 2'b11
    } rx_fmt_e;

    typedef enum logic [1:0] {
        ST_ARM   = 2'b00,
        ST_SYNC  = 2'b01,
        ST_LEFT  = 2'b10,
        ST_RIGHT = 2'b11
    } rx_state_e;

    // width code to word length in bits
    function automatic logic [4:0] word_len(input logic [1:0] code);
        logic [4:0] n;
        unique case (code)
            2'b00:   n = 5'd16;
            2'b01:   n = 5'd18;
            2'b10:   n = 5'd20;
            default: n = 5'd24;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/serial_audio_rx_sync.sv
module serial_audio_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic lr_i,
    input  logic dat_i,
    output logic bit_rise,
    output logic lr_o,
    output logic dat_o
);
    localparam int LAST = STAGES - 1;

    // bit 2: bit clock, bit 1: channel clock, bit 0: data
    logic [2:0] chain [STAGES];
    logic       bclk_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            bclk_d <= 1'b0;
        end else begin
            chain[0] <= {bclk_i, lr_i, dat_i};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            bclk_d <= chain[LAST][2];
        end
    end

    assign bit_rise = chain[LAST][2] & ~bclk_d;
    assign lr_o     = chain[LAST][1];
    assign dat_o    = chain[LAST][0];

endmodule

// File: rtl/serial_audio_rx_frame.sv
module serial_audio_rx_frame
    import serial_audio_rx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_rise,
    input  logic                lr_bit,
    input  logic                dat_bit,
    input  logic [1:0]          fmt_sel,
    input  logic [1:0]          width_sel,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_valid,
    output logic                out_right
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    rx_state_e           state, state_n;
    logic [CNT_W-1:0]    cnt;
    logic [SAMPLE_W-1:0] shreg;
    logic [1:0]          fmt_q, wid_q;

    logic                take_cfg, half_start, emit, keep_bit;
    logic [1:0]          fmt_use, wid_use;
    logic [4:0]          n_use, n_old;
    logic [CNT_W-1:0]    k_use;
    logic [SAMPLE_W-1:0] fill_mask, ext_word;

    // next-state decision, only on a bit-clock rise
    always_comb begin
        state_n    = state;
        take_cfg   = 1'b0;
        half_start = 1'b0;
        emit       = 1'b0;
        if (bit_rise) begin
            unique case (state)
                ST_ARM:   if (lr_bit) state_n = ST_SYNC;
                ST_SYNC:  if (!lr_bit) begin
                              state_n = ST_LEFT; take_cfg = 1'b1; half_start = 1'b1;
                          end
                ST_LEFT:  if (lr_bit) begin
                              state_n = ST_RIGHT; half_start = 1'b1; emit = 1'b1;
                          end
                ST_RIGHT: if (!lr_bit) begin
                              state_n = ST_LEFT; half_start = 1'b1; emit = 1'b1; take_cfg = 1'b1;
                          end
                default:  state_n = ST_ARM;
            endcase
        end
    end

    // bit window selection for the current bit index
    always_comb begin
        fmt_use = take_cfg ? fmt_sel   : fmt_q;
        wid_use = take_cfg ? width_sel : wid_q;
        n_use   = word_len(wid_use);
        k_use   = half_start ? '0 : cnt;
        unique case (rx_fmt_e'(fmt_use))
            FMT_RJUST: keep_bit = 1'b1;
            FMT_LJUST: keep_bit = int'(k_use) < int'(n_use);
            default:   keep_bit = (int'(k_use) >= 1) && (int'(k_use) <= int'(n_use));
        endcase
    end

    // sign extension with the width in force for the finished half-frame
    always_comb begin
        n_old     = word_len(wid_q);
        fill_mask = {SAMPLE_W{1'b1}} << n_old;
        ext_word  = shreg[n_old - 5'd1] ? (shreg | fill_mask) : (shreg & ~fill_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ARM;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            shreg     <= '0;
            fmt_q     <= 2'b00;
            wid_q     <= 2'b00;
            out_data  <= '0;
            out_valid <= 1'b0;
            out_right <= 1'b0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_data  <= ext_word;
                out_right <= (state == ST_RIGHT);
            end
            if (take_cfg) begin
                fmt_q <= fmt_sel;
                wid_q <= width_sel;
            end
            if (half_start) begin
                shreg <= keep_bit ? {{(SAMPLE_W-1){1'b0}}, dat_bit} : '0;
                cnt   <= CNT_W'(1);
            end else if (bit_rise && (state == ST_LEFT || state == ST_RIGHT)) begin
                if (keep_bit) shreg <= {shreg[SAMPLE_W-2:0], dat_bit};
                if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
            end
        end
    end

    a_r1_emit_only_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(state == ST_LEFT || state == ST_RIGHT));

    a_r2_flag_matches_channel: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_right == (state == ST_LEFT)));

    a_r3_shift_on_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_rise |=> $stable(shreg));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r11_cfg_held_in_state: assert property (@(posedge clk) disable iff (!rst_n)
        (state == $past(state)) |-> ($stable(fmt_q) && $stable(wid_q)));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
    parameter int SAMPLE_W    = 24,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_in,
    input  logic                lrclk_in,
    input  logic                sdata_in,
    input  logic [1:0]          fmt_sel,
    input  logic [1:0]          width_sel,
    output logic [SAMPLE_W-1:0] smp_data,
    output logic                smp_valid,
    output logic                smp_right
);
    logic bit_rise, lr_bit, dat_bit;

    serial_audio_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_i   (bclk_in),
        .lr_i     (lrclk_in),
        .dat_i    (sdata_in),
        .bit_rise (bit_rise),
        .lr_o     (lr_bit),
        .dat_o    (dat_bit)
    );

    serial_audio_rx_frame #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_rise  (bit_rise),
        .lr_bit    (lr_bit),
        .dat_bit   (dat_bit),
        .fmt_sel   (fmt_sel),
        .width_sel (width_sel),
        .out_data  (smp_data),
        .out_valid (smp_valid),
        .out_right (smp_right)
    );

endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, lrc = 1'b0, sd = 1'b0;
    logic [1:0]  fmt = 2'b01, wsel = 2'b11;
    logic [23:0] smp_data;
    logic        smp_valid, smp_right;

    int n_vec = 0, n_bad = 0, n_slot = 0, n_pulse = 0;
    bit done = 0, glitch_high = 0;
    bit          pend_v = 0;
    logic [23:0] pend_w = '0;
    logic        pend_r = 1'b0;

    serial_audio_rx i_serial_audio_rx (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .lrclk_in(lrc), .sdata_in(sd),
        .fmt_sel(fmt), .width_sel(wsel),
        .smp_data(smp_data), .smp_valid(smp_valid), .smp_right(smp_right)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rst_n && smp_valid) n_pulse++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic int wn(input int wc);
        case (wc)
            0: return 16;
            1: return 18;
            2: return 20;
            default: return 24;
        endcase
    endfunction

    function automatic logic [23:0] sx(input logic [23:0] w, input int n);
        logic [23:0] m;
        m = 24'hFFFFFF << n;
        return w[n-1] ? (w | m) : (w & ~m);
    endfunction

    // f: 1 left-justified, 2 right-justified, other I2S; outside the window a filler pattern
    function automatic logic mkbit(input int f, input int n, input int len, input int k, input logic [23:0] w);
        logic fill;
        fill = k[0];
        if (f == 1)      return (k < n) ? w[n-1-k] : fill;
        else if (f == 2) return (k >= len - n) ? w[len-1-k] : fill;
        else             return (k >= 1 && k <= n) ? w[n-k] : fill;
    endfunction

    // one bit period: fall, data set, rise, then sample the slot 3 edges after the rise
    task automatic tick(input logic l, input logic d, output logic v, output logic [23:0] q, output logic r);
        @(negedge clk);
        bclk = 1'b0; lrc = l; sd = d;
        repeat (HALF) @(negedge clk);
        bclk = 1'b1;
        repeat (3) @(negedge clk);
        v = smp_valid; q = smp_data; r = smp_right;
        if (v) n_slot++;
        if (glitch_high) sd = ~d;
    endtask

    task automatic send_half(input logic l, input logic [23:0] w, input int f, input int wc,
                             input int len, input bit keep, input string req);
        logic v, r;
        logic [23:0] q;
        bit extra;
        int n;
        extra = 0;
        n = wn(wc);
        for (int k = 0; k < len; k++) begin
            tick(l, mkbit(f, n, len, k, w), v, q, r);
            if (k == 0) begin
                if (pend_v) chk(v === 1'b1 && q === pend_w && r === pend_r, req,
                                {7'b0, r, q}, {7'b0, pend_r, pend_w});
                else        chk(v === 1'b0, "R1 no emission", {31'b0, v}, 32'h0);
            end else if (v) extra = 1;
        end
        chk(!extra, "R10 strobe only at half start", {31'b0, extra}, 32'h0);
        pend_v = keep; pend_w = sx(w, n); pend_r = l;
    endtask

    task automatic t_reset;
        chk(smp_valid === 1'b0 && smp_data === 24'h0 && smp_right === 1'b0, "R1 reset",
            {7'b0, smp_right, smp_data}, 32'h0);
        repeat (5) begin
            @(negedge clk); sd = ~sd;
        end
        repeat (20) @(negedge clk);
        chk(n_pulse == 0, "R3 idle bit clock", n_pulse, 0);
    endtask

    task automatic t_startup;
        fmt = 2'b01; wsel = 2'b11;
        send_half(1'b0, 24'h123456, 1, 3, 5, 0, "R1");
        send_half(1'b1, 24'h654321, 1, 3, 32, 0, "R1");
        send_half(1'b0, 24'hC00003, 1, 3, 32, 1, "R1");
        send_half(1'b1, 24'h2468AC, 1, 3, 32, 1, "R2 left emitted");
    endtask

    task automatic t_ljust;
        glitch_high = 1;
        send_half(1'b0, 24'h800001, 1, 3, 32, 1, "R2 R4 right emitted");
        send_half(1'b1, 24'h7FFFFE, 1, 3, 32, 1, "R3 R4 R8");
        glitch_high = 0;
        send_half(1'b0, 24'h5A5A5A, 1, 3, 32, 1, "R3 R4 R8");
    endtask

    task automatic t_i2s;
        fmt = 2'b00; wsel = 2'b00;
        send_half(1'b1, 24'h000000, 1, 3, 32, 1, "R4");
        send_half(1'b0, 24'h008123, 0, 0, 32, 1, "R5");
        send_half(1'b1, 24'h001234, 0, 0, 32, 1, "R5 R7 R8");
        send_half(1'b0, 24'h00F00F, 0, 0, 32, 1, "R5 R7 R8");
    endtask

    task automatic t_rjust;
        fmt = 2'b10; wsel = 2'b10;
        send_half(1'b1, 24'h0000FF, 0, 0, 32, 1, "R5");
        send_half(1'b0, 24'h0A5A5A, 2, 2, 32, 1, "R6");
        send_half(1'b1, 24'h03C3C3, 2, 2, 24, 1, "R6 R8");
        send_half(1'b0, 24'h08000F, 2, 2, 20, 1, "R6 R8");
    endtask

    task automatic t_spare_and_short;
        fmt = 2'b11; wsel = 2'b01;
        send_half(1'b1, 24'h000001, 2, 2, 32, 1, "R6");
        send_half(1'b0, 24'h02ABCD, 0, 1, 32, 1, "R6 R9");
        send_half(1'b1, 24'h015555, 0, 1, 19, 1, "R5 spare code R8");
        fmt = 2'b01; wsel = 2'b00;
        send_half(1'b0, 24'h00BEEF, 1, 0, 16, 1, "R5 spare code R8");
        send_half(1'b1, 24'h007FFF, 1, 0, 20, 1, "R4 short half R7");
    endtask

    task automatic t_cfg_latch;
        fmt = 2'b01; wsel = 2'b11;
        send_half(1'b0, 24'hF12345, 1, 3, 32, 1, "R4 R7");
        fmt = 2'b10; wsel = 2'b00;
        send_half(1'b1, 24'h876543, 1, 3, 32, 1, "R11 left with old config");
        send_half(1'b0, 24'h00C001, 2, 0, 32, 1, "R11 right with old config");
        send_half(1'b1, 24'h003FFE, 2, 0, 32, 1, "R11 new config from left start");
        send_half(1'b0, 24'h000000, 2, 0, 2, 0, "R11 R9 final right");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired act=%0d exp=%0d", n_vec, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_startup();
        t_ljust();
        t_i2s();
        t_rjust();
        t_spare_and_short();
        t_cfg_latch();
        repeat (10) @(negedge clk);
        chk(n_pulse == n_slot, "R10 pulse timing and width", n_pulse, n_slot);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule